// File: doc/BRIEF.md
# Battery Charge Accounting Counters

This block keeps the charge ledger of a battery gauge. Upstream logic turns sensed current and elapsed time into single-cycle count strobes that are already corrected for rate and temperature. The block uses those strobes to keep four counts: the charge still available in the battery, the charge drawn since the last full state, the self-discharge charged against the battery since the last full state, and the battery capacity it has learned. It also keeps a pair of cycle counters and four status flags.

The learned capacity comes from the block's own measurements. A discharge that runs from the full state down to the empty voltage is qualified only if three things hold. No sustained charge may occur along the way. Self-discharge must stay limited. The temperature must not be below freezing when empty is reached. On the first charge strobe after such a discharge, the drawn-charge count becomes the new capacity. A host can overwrite the available charge and the learned capacity. A strap input chooses whether a reset starts the battery empty or full.

Top module: `charge_acct`

## Requirements
- R1: The available charge rises by one on each charge event while it is below the learned capacity and holds once it reaches it. It falls by one on each discharge or self-discharge event and never drops below zero.
- R2: The drawn-charge count rises on every discharge event, and on a self-discharge event only while available charge is non-zero. It saturates at 0xFFFF. In every cycle that begins with available charge equal to capacity, it restarts from zero, and that cycle's event still counts.
- R3: A valid charge is the 257th charge event since the last discharge event, and it is flagged once per run. If the empty flag is set at that moment, the valid charge clears available charge to zero and clears the empty flag.
- R4: The first charge event taken while both the empty flag and the valid-discharge flag are set copies the drawn-charge count into the learned capacity. The same event clears the capacity-inaccurate counter and flag and the valid-discharge flag.
- R5: The valid-discharge flag sets on a discharge event taken at the full state. It clears on a capacity update or a valid charge. It also clears on a self-discharge event that brings the self-discharge count to 4096 or more. It also clears when empty is first flagged while the temperature step code is below 4 (code 4 is 0 to 10 °C, each code one 10 °C step).
- R6: The capacity-inaccurate counter rises by one per valid charge and saturates at 255. The capacity-inaccurate flag sets on the valid charge that brings the counter to 64.
- R7: A reset (synchronous low level on rst_n, or a high level on reset_req) loads capacity from pfc_val. It clears the drawn-charge, self-discharge, capacity-inaccurate and full-event counters and the valid-discharge and empty flags, and it sets the capacity-inaccurate and battery-replaced flags. Available charge is cleared, or loaded with pfc_val when preload_n is low.
- R8: The battery-replaced flag holds until a cycle begins with available charge equal to capacity, or until empty is first flagged.
- R9: The empty flag sets in the cycle after empty_v is high and holds until a valid charge.
- R10: The full-event counter advances once for every 16 full events and saturates at 255. A full event is a charge event that brings available charge up to capacity while detection is armed. Detection is armed by reset or by a discharge event, but not by self-discharge, and each full event disarms it.
- R11: The 13-bit self-discharge count rises on each self-discharge event and saturates at 8191. Like the drawn-charge count, it restarts from zero in every cycle that begins at the full state.
- R12: At most one event is taken per cycle. A discharge strobe wins over a charge strobe, and a charge strobe wins over a self-discharge strobe.
- R13: A host write with host_sel 0 loads available charge, and one with host_sel 1 loads learned capacity. Either write wins over every other update to that register. A write with host_sel 2 or 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reset_req | input | 1 | Reset request, active high, same effect as rst_n |
| preload_n | input | 1 | Strap read at reset: low starts the battery full |
| pfc_val | input | CW | Programmed full count |
| chg_stb | input | 1 | Compensated charge count strobe |
| dsg_stb | input | 1 | Compensated discharge count strobe |
| sdsg_stb | input | 1 | Self-discharge count strobe |
| empty_v | input | 1 | End-of-discharge voltage reached |
| temp_step | input | TEMPW | Temperature step code, 10 °C per step |
| host_we | input | 1 | Host write enable |
| host_sel | input | 2 | Host target: 0 available, 1 capacity |
| host_wdata | input | CW | Host write data |
| avail_q | output | CW | Available charge |
| dcount_q | output | CW | Drawn-charge count since full |
| cap_q | output | CW | Learned capacity |
| sd_cnt_q | output | SDW | Self-discharge count since full |
| cpi_q | output | CPIW | Capacity-inaccurate counter |
| full_cnt_q | output | FCW | Full-event counter |
| vdq_q | output | 1 | Valid-discharge flag |
| ci_q | output | 1 | Capacity-inaccurate flag |
| brp_q | output | 1 | Battery-replaced flag |
| edv_q | output | 1 | Empty flag |

## Verification
The ledger is driven with mixed runs of charge, discharge and self-discharge strobes. These runs separate the floor at zero, the ceiling at capacity, and the rule that self-discharge stops feeding the drawn-charge count once the battery is empty. A full-to-empty discharge is run once at room temperature and once below freezing, with extra discharge past zero so that the learned capacity differs from the programmed count. This tells an update from a blocked one. Further runs drive the self-discharge count to one below and exactly at its limit, repeat valid charges until the inaccuracy counter passes 64 and 255, and send 16 full events with a self-discharge between them that must not re-arm detection. Other runs send simultaneous charge and discharge strobes and host writes to all four selector values.

// File: rtl/chg_acct_pkg.sv
package chg_acct_pkg;

  // host write target codes
  typedef enum logic [1:0] {
    HSEL_AVAIL = 2'd0,
    HSEL_CAP   = 2'd1
  } host_sel_e;

  // saturating increment, widths handled by the caller's cast
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned top);
    return (v >= top) ? top : v + 1;
  endfunction

endpackage

// File: rtl/chg_acct_arb.sv
module chg_acct_arb #(
  parameter int VCHG_CNT = 256
) (
  input  logic clk,
  input  logic init,
  input  logic chg_stb,
  input  logic dsg_stb,
  input  logic sdsg_stb,
  output logic ev_chg,
  output logic ev_dsg,
  output logic ev_sd,
  output logic vchg
);
  localparam int RW = $clog2(VCHG_CNT + 2);

  logic [RW-1:0] run_q;

  // one event per cycle: discharge, then charge, then self-discharge
  assign ev_dsg = dsg_stb;
  assign ev_chg = chg_stb & ~dsg_stb;
  assign ev_sd  = sdsg_stb & ~dsg_stb & ~chg_stb;

  // the event that takes the run past the threshold is the valid charge
  assign vchg = ev_chg && (run_q == RW'(VCHG_CNT));

  always_ff @(posedge clk) begin
    if (init)                                    run_q <= '0;
    else if (ev_dsg)                             run_q <= '0;
    else if (ev_chg && run_q <= RW'(VCHG_CNT))   run_q <= run_q + RW'(1);
  end
endmodule

// File: rtl/chg_acct_cnt.sv
module chg_acct_cnt
  import chg_acct_pkg::*;
#(
  parameter int CW       = 16,
  parameter int SDW      = 13,
  parameter int SD_LIMIT = 4096,
  parameter int FCW      = 8,
  parameter int FULL_DIV = 16
) (
  input  logic           clk,
  input  logic           init,
  input  logic           preload,
  input  logic [CW-1:0]  pfc_val,
  input  logic           ev_chg,
  input  logic           ev_dsg,
  input  logic           ev_sd,
  input  logic           vchg,
  input  logic           edv_q,
  input  logic [CW-1:0]  cap_q,
  input  logic           wr_avail,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  avail_q,
  output logic [CW-1:0]  dcount_q,
  output logic [SDW-1:0] sd_cnt_q,
  output logic [FCW-1:0] full_cnt_q,
  output logic           sd_over,
  output logic           full_evt,
  output logic           at_full
);
  localparam int PW      = (FULL_DIV > 1) ? $clog2(FULL_DIV) : 1;
  localparam int DC_TOP  = (1 << CW) - 1;
  localparam int SD_TOP  = (1 << SDW) - 1;
  localparam int FC_TOP  = (1 << FCW) - 1;

  logic [CW-1:0]  avail_n, dc_base, dcount_n;
  logic [SDW-1:0] sd_base, sd_n;
  logic [PW-1:0]  presc_q;
  logic           armed_q, dc_inc, empty_clr;

  assign at_full   = (avail_q == cap_q);
  assign empty_clr = vchg && edv_q;

  always_comb begin
    avail_n = avail_q;
    if (wr_avail)                                   avail_n = wdata;
    else if (empty_clr)                             avail_n = '0;
    else if (ev_chg && avail_q < cap_q)             avail_n = avail_q + CW'(1);
    else if ((ev_dsg || ev_sd) && avail_q != '0)    avail_n = avail_q - CW'(1);
  end

  assign full_evt = ev_chg && armed_q && !wr_avail && !empty_clr &&
                    (avail_q < cap_q) && (avail_q + CW'(1) == cap_q);

  // drawn-charge and self-discharge counts restart from the full state
  assign dc_base  = at_full ? '0 : dcount_q;
  assign dc_inc   = ev_dsg || (ev_sd && avail_q != '0);
  assign dcount_n = dc_inc ? CW'(sat_inc(32'(dc_base), DC_TOP)) : dc_base;

  assign sd_base  = at_full ? '0 : sd_cnt_q;
  assign sd_n     = ev_sd ? SDW'(sat_inc(32'(sd_base), SD_TOP)) : sd_base;
  assign sd_over  = ev_sd && (32'(sd_n) >= SD_LIMIT);

  always_ff @(posedge clk) begin
    if (init) begin
      avail_q    <= preload ? pfc_val : '0;
      dcount_q   <= '0;
      sd_cnt_q   <= '0;
      armed_q    <= 1'b1;
      presc_q    <= '0;
      full_cnt_q <= '0;
    end else begin
      avail_q  <= avail_n;
      dcount_q <= dcount_n;
      sd_cnt_q <= sd_n;
      if (ev_dsg)        armed_q <= 1'b1;
      else if (full_evt) armed_q <= 1'b0;
      if (full_evt) begin
        if (presc_q == PW'(FULL_DIV - 1)) begin
          presc_q    <= '0;
          full_cnt_q <= FCW'(sat_inc(32'(full_cnt_q), FC_TOP));
        end else begin
          presc_q <= presc_q + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/chg_acct_learn.sv
module chg_acct_learn
  import chg_acct_pkg::*;
#(
  parameter int CW          = 16,
  parameter int CPIW        = 8,
  parameter int CI_LIMIT    = 64,
  parameter int TEMPW       = 4,
  parameter int FREEZE_CODE = 4
) (
  input  logic             clk,
  input  logic             init,
  input  logic [CW-1:0]    pfc_val,
  input  logic             ev_chg,
  input  logic             ev_dsg,
  input  logic             vchg,
  input  logic             at_full,
  input  logic             sd_over,
  input  logic             empty_v,
  input  logic [TEMPW-1:0] temp_step,
  input  logic [CW-1:0]    dcount_q,
  input  logic             wr_cap,
  input  logic [CW-1:0]    wdata,
  output logic [CW-1:0]    cap_q,
  output logic [CPIW-1:0]  cpi_q,
  output logic             ci_q,
  output logic             vdq_q,
  output logic             brp_q,
  output logic             edv_q,
  output logic             learn,
  output logic             empty_evt
);
  localparam int CPI_TOP = (1 << CPIW) - 1;

  logic cold_empty, vdq_kill;

  assign empty_evt  = empty_v && !edv_q;
  assign cold_empty = empty_evt && (temp_step < TEMPW'(FREEZE_CODE));
  // qualification collapses into the valid-discharge flag
  assign learn      = ev_chg && edv_q && vdq_q;
  assign vdq_kill   = learn || vchg || sd_over || cold_empty;

  always_ff @(posedge clk) begin
    if (init) begin
      cap_q <= pfc_val;
      cpi_q <= '0;
      ci_q  <= 1'b1;
      vdq_q <= 1'b0;
      brp_q <= 1'b1;
      edv_q <= 1'b0;
    end else begin
      if (wr_cap)     cap_q <= wdata;
      else if (learn) cap_q <= dcount_q;

      if (learn)     cpi_q <= '0;
      else if (vchg) cpi_q <= CPIW'(sat_inc(32'(cpi_q), CPI_TOP));

      if (learn)                                         ci_q <= 1'b0;
      else if (vchg && cpi_q >= CPIW'(CI_LIMIT - 1))     ci_q <= 1'b1;

      if (vdq_kill)                vdq_q <= 1'b0;
      else if (ev_dsg && at_full)  vdq_q <= 1'b1;

      if (at_full || empty_evt) brp_q <= 1'b0;

      edv_q <= empty_v || (edv_q && !vchg);
    end
  end
endmodule

// File: rtl/charge_acct.sv
module charge_acct
  import chg_acct_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SDW         = 13,
  parameter int CPIW        = 8,
  parameter int FCW         = 8,
  parameter int TEMPW       = 4,
  parameter int VCHG_CNT    = 256,
  parameter int SD_LIMIT    = 4096,
  parameter int CI_LIMIT    = 64,
  parameter int FULL_DIV    = 16,
  parameter int FREEZE_CODE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_req,
  input  logic             preload_n,
  input  logic [CW-1:0]    pfc_val,
  input  logic             chg_stb,
  input  logic             dsg_stb,
  input  logic             sdsg_stb,
  input  logic             empty_v,
  input  logic [TEMPW-1:0] temp_step,
  input  logic             host_we,
  input  logic [1:0]       host_sel,
  input  logic [CW-1:0]    host_wdata,
  output logic [CW-1:0]    avail_q,
  output logic [CW-1:0]    dcount_q,
  output logic [CW-1:0]    cap_q,
  output logic [SDW-1:0]   sd_cnt_q,
  output logic [CPIW-1:0]  cpi_q,
  output logic [FCW-1:0]   full_cnt_q,
  output logic             vdq_q,
  output logic             ci_q,
  output logic             brp_q,
  output logic             edv_q
);
  // named internal events, visible to the bound checker
  logic init, wr_avail, wr_cap;
  logic ev_chg, ev_dsg, ev_sd, vchg;
  logic sd_over, full_evt, at_full, learn, empty_evt;

  assign init     = !rst_n || reset_req;
  assign wr_avail = host_we && (host_sel == HSEL_AVAIL);
  assign wr_cap   = host_we && (host_sel == HSEL_CAP);

  chg_acct_arb #(.VCHG_CNT(VCHG_CNT)) u_arb (
    .clk(clk), .init(init),
    .chg_stb(chg_stb), .dsg_stb(dsg_stb), .sdsg_stb(sdsg_stb),
    .ev_chg(ev_chg), .ev_dsg(ev_dsg), .ev_sd(ev_sd), .vchg(vchg)
  );

  chg_acct_cnt #(
    .CW(CW), .SDW(SDW), .SD_LIMIT(SD_LIMIT), .FCW(FCW), .FULL_DIV(FULL_DIV)
  ) u_cnt (
    .clk(clk), .init(init), .preload(!preload_n), .pfc_val(pfc_val),
    .ev_chg(ev_chg), .ev_dsg(ev_dsg), .ev_sd(ev_sd), .vchg(vchg),
    .edv_q(edv_q), .cap_q(cap_q), .wr_avail(wr_avail), .wdata(host_wdata),
    .avail_q(avail_q), .dcount_q(dcount_q), .sd_cnt_q(sd_cnt_q),
    .full_cnt_q(full_cnt_q), .sd_over(sd_over), .full_evt(full_evt),
    .at_full(at_full)
  );

  chg_acct_learn #(
    .CW(CW), .CPIW(CPIW), .CI_LIMIT(CI_LIMIT), .TEMPW(TEMPW),
    .FREEZE_CODE(FREEZE_CODE)
  ) u_learn (
    .clk(clk), .init(init), .pfc_val(pfc_val),
    .ev_chg(ev_chg), .ev_dsg(ev_dsg), .vchg(vchg), .at_full(at_full),
    .sd_over(sd_over), .empty_v(empty_v), .temp_step(temp_step),
    .dcount_q(dcount_q), .wr_cap(wr_cap), .wdata(host_wdata),
    .cap_q(cap_q), .cpi_q(cpi_q), .ci_q(ci_q), .vdq_q(vdq_q),
    .brp_q(brp_q), .edv_q(edv_q), .learn(learn), .empty_evt(empty_evt)
  );
endmodule

// File: rtl/charge_acct_chk.sv
module charge_acct_chk #(
  parameter int CW          = 16,
  parameter int SDW         = 13,
  parameter int CPIW        = 8,
  parameter int FCW         = 8,
  parameter int TEMPW       = 4,
  parameter int CI_LIMIT    = 64,
  parameter int FREEZE_CODE = 4
) (
  input logic             clk,
  input logic             init,
  input logic             chg_stb,
  input logic             dsg_stb,
  input logic             host_we,
  input logic             wr_avail,
  input logic             wr_cap,
  input logic [TEMPW-1:0] temp_step,
  input logic             ev_chg,
  input logic             ev_dsg,
  input logic             ev_sd,
  input logic             vchg,
  input logic             learn,
  input logic             empty_evt,
  input logic [CW-1:0]    avail_q,
  input logic [CW-1:0]    dcount_q,
  input logic [CW-1:0]    cap_q,
  input logic [SDW-1:0]   sd_cnt_q,
  input logic [CPIW-1:0]  cpi_q,
  input logic [FCW-1:0]   full_cnt_q,
  input logic             ci_q,
  input logic             vdq_q,
  input logic             brp_q,
  input logic             edv_q
);
  logic [1:0] live_q;
  logic       off;

  always_ff @(posedge clk) begin
    if (init) live_q <= 2'b00;
    else      live_q <= {live_q[0], 1'b1};
  end
  assign off = init || !live_q[1];

  AST_AVAIL_CEIL: assert property (@(posedge clk) disable iff (off)
    (ev_chg && avail_q >= cap_q && !host_we && !(vchg && edv_q)) |=> avail_q == $past(avail_q)); // R1
  AST_AVAIL_FLOOR: assert property (@(posedge clk) disable iff (off)
    (avail_q == '0 && (ev_dsg || ev_sd) && !host_we) |=> avail_q == '0); // R1
  AST_DCOUNT_SAT: assert property (@(posedge clk) disable iff (off)
    (dcount_q == '1 && avail_q != cap_q) |=> dcount_q == '1); // R2
  AST_EMPTY_CLEARS_AVAIL: assert property (@(posedge clk) disable iff (off)
    (vchg && edv_q && !wr_avail) |=> avail_q == '0); // R3
  AST_LEARN_COPY: assert property (@(posedge clk) disable iff (off)
    (learn && !wr_cap) |=> cap_q == $past(dcount_q)); // R4
  AST_VDQ_FREEZE: assert property (@(posedge clk) disable iff (off)
    (empty_evt && temp_step < TEMPW'(FREEZE_CODE)) |=> !vdq_q); // R5
  AST_CPI_NOWRAP: assert property (@(posedge clk) disable iff (off)
    (cpi_q == '1 && !learn) |=> cpi_q == '1); // R6
  AST_CI_FLAGGED: assert property (@(posedge clk) disable iff (off)
    (cpi_q >= CPIW'(CI_LIMIT)) |-> ci_q); // R6
  AST_BRP_DROP: assert property (@(posedge clk) disable iff (off)
    (brp_q && avail_q == cap_q) |=> !brp_q); // R8
  AST_EDV_HOLD: assert property (@(posedge clk) disable iff (off)
    (edv_q && !vchg) |=> edv_q); // R9
  AST_FULLCNT_STEP: assert property (@(posedge clk) disable iff (off)
    (full_cnt_q == $past(full_cnt_q)) || (full_cnt_q == $past(full_cnt_q) + FCW'(1))); // R10
  AST_SD_NOWRAP: assert property (@(posedge clk) disable iff (off)
    (sd_cnt_q == '1 && avail_q != cap_q) |=> sd_cnt_q == '1); // R11
  AST_DSG_WINS: assert property (@(posedge clk) disable iff (off)
    (chg_stb && dsg_stb && avail_q != '0 && !wr_avail) |=> avail_q == $past(avail_q) - CW'(1)); // R12
endmodule

bind charge_acct charge_acct_chk #(
  .CW(CW), .SDW(SDW), .CPIW(CPIW), .FCW(FCW), .TEMPW(TEMPW),
  .CI_LIMIT(CI_LIMIT), .FREEZE_CODE(FREEZE_CODE)
) u_chk (
  .clk(clk), .init(init), .chg_stb(chg_stb), .dsg_stb(dsg_stb),
  .host_we(host_we), .wr_avail(wr_avail), .wr_cap(wr_cap), .temp_step(temp_step),
  .ev_chg(ev_chg), .ev_dsg(ev_dsg), .ev_sd(ev_sd), .vchg(vchg),
  .learn(learn), .empty_evt(empty_evt),
  .avail_q(avail_q), .dcount_q(dcount_q), .cap_q(cap_q), .sd_cnt_q(sd_cnt_q),
  .cpi_q(cpi_q), .full_cnt_q(full_cnt_q), .ci_q(ci_q), .vdq_q(vdq_q),
  .brp_q(brp_q), .edv_q(edv_q)
);

// File: tb/tb_charge_acct.sv
module tb_charge_acct;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, reset_req = 1'b0, preload_n = 1'b1;
  logic [15:0] pfc_val = 16'd300;
  logic        chg_stb = 1'b0, dsg_stb = 1'b0, sdsg_stb = 1'b0, empty_v = 1'b0;
  logic [3:0]  temp_step = 4'd6;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] avail_q, dcount_q, cap_q;
  logic [12:0] sd_cnt_q;
  logic [7:0]  cpi_q, full_cnt_q;
  logic        vdq_q, ci_q, brp_q, edv_q;

  int checks = 0;
  int fails  = 0;

  localparam int K_CHG = 0;
  localparam int K_DSG = 1;
  localparam int K_SD  = 2;

  // {kind, strobe count, expected available charge, expected drawn count}
  localparam logic [49:0] VEC [8] = '{
    {2'd0, 16'd10,  16'd10,  16'd0},
    {2'd1, 16'd3,   16'd7,   16'd3},
    {2'd2, 16'd2,   16'd5,   16'd5},
    {2'd1, 16'd10,  16'd0,   16'd15},
    {2'd2, 16'd4,   16'd0,   16'd15},
    {2'd0, 16'd300, 16'd300, 16'd0},
    {2'd0, 16'd5,   16'd300, 16'd0},
    {2'd1, 16'd1,   16'd299, 16'd1}
  };

  always #10 clk = ~clk;

  charge_acct dut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .preload_n(preload_n),
    .pfc_val(pfc_val), .chg_stb(chg_stb), .dsg_stb(dsg_stb), .sdsg_stb(sdsg_stb),
    .empty_v(empty_v), .temp_step(temp_step), .host_we(host_we),
    .host_sel(host_sel), .host_wdata(host_wdata),
    .avail_q(avail_q), .dcount_q(dcount_q), .cap_q(cap_q), .sd_cnt_q(sd_cnt_q),
    .cpi_q(cpi_q), .full_cnt_q(full_cnt_q), .vdq_q(vdq_q), .ci_q(ci_q),
    .brp_q(brp_q), .edv_q(edv_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // n strobes of one kind on consecutive cycles, then one idle cycle
  task automatic run(input int kind, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chg_stb  = (kind == K_CHG);
      dsg_stb  = (kind == K_DSG);
      sdsg_stb = (kind == K_SD);
    end
    @(negedge clk);
    chg_stb = 1'b0; dsg_stb = 1'b0; sdsg_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_empty();
    @(negedge clk); empty_v = 1'b1;
    @(negedge clk); empty_v = 1'b0;
    @(negedge clk);
  endtask

  task automatic soft_reset(input logic pre_n);
    @(negedge clk); preload_n = pre_n; reset_req = 1'b1;
    @(negedge clk); reset_req = 1'b0; preload_n = 1'b1;
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk); host_we = 1'b1; host_sel = sel; host_wdata = val;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R7 reset state through rst_n
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R7 avail after reset", avail_q, 0);
    chk("R7 capacity from pfc", cap_q, 300);
    chk("R7 drawn count", dcount_q, 0);
    chk("R7 ci flag set", ci_q, 1);
    chk("R7 brp flag set", brp_q, 1);
    chk("R7 vdq clear", vdq_q, 0);
    chk("R7 cpi clear", cpi_q, 0);

    // R1 R2 table of strobe runs
    for (int i = 0; i < 8; i++) begin
      run(int'(VEC[i][49:48]), int'(VEC[i][47:32]));
      chk($sformatf("R1 table step %0d avail", i), avail_q, VEC[i][31:16]);
      chk($sformatf("R2 table step %0d drawn", i), dcount_q, VEC[i][15:0]);
    end
    chk("R5 vdq set on discharge from full", vdq_q, 1);
    chk("R6 cpi after one valid charge", cpi_q, 1);

    // R4 qualified discharge with extra drawn count past zero
    run(K_DSG, 310);
    chk("R2 drawn keeps counting at zero", dcount_q, 311);
    pulse_empty();
    chk("R9 empty latched", edv_q, 1);
    run(K_CHG, 1);
    chk("R4 capacity learned", cap_q, 311);
    chk("R4 vdq cleared by update", vdq_q, 0);
    chk("R4 ci cleared by update", ci_q, 0);
    chk("R4 cpi cleared by update", cpi_q, 0);
    chk("R1 first charge after empty", avail_q, 1);
    run(K_CHG, 256);
    chk("R3 valid charge clears avail", avail_q, 0);
    chk("R3 valid charge clears empty", edv_q, 0);
    chk("R6 cpi counts valid charge", cpi_q, 1);

    // R6 inaccuracy counter thresholds
    for (int i = 0; i < 62; i++) begin run(K_DSG, 1); run(K_CHG, 257); end
    chk("R6 cpi at 63", cpi_q, 63);
    chk("R6 ci still clear at 63", ci_q, 0);
    run(K_DSG, 1); run(K_CHG, 257);
    chk("R6 cpi at 64", cpi_q, 64);
    chk("R6 ci set at 64", ci_q, 1);
    for (int i = 0; i < 192; i++) begin run(K_DSG, 1); run(K_CHG, 257); end
    chk("R6 cpi saturates", cpi_q, 255);

    // R13 host writes
    host_write(2'd0, 16'd100);
    chk("R13 write avail", avail_q, 100);
    host_write(2'd1, 16'd200);
    chk("R13 write capacity", cap_q, 200);
    host_write(2'd2, 16'd55);
    host_write(2'd3, 16'd77);
    chk("R13 unused select avail", avail_q, 100);
    chk("R13 unused select capacity", cap_q, 200);

    // R2 saturation
    run(K_DSG, 65540);
    chk("R2 drawn saturates", dcount_q, 16'hFFFF);
    chk("R1 floor after long discharge", avail_q, 0);

    // R5 cold empty blocks learning; R7 preload; R8 brp
    soft_reset(1'b0);
    chk("R7 preload fills avail", avail_q, 300);
    chk("R8 brp set after reset", brp_q, 1);
    @(negedge clk);
    chk("R8 brp clears at full", brp_q, 0);
    temp_step = 4'd3;
    run(K_DSG, 1);
    chk("R5 vdq set cold run", vdq_q, 1);
    run(K_DSG, 304);
    chk("R2 drawn cold run", dcount_q, 305);
    pulse_empty();
    chk("R5 vdq cleared by cold empty", vdq_q, 0);
    run(K_CHG, 1);
    chk("R4 no update after cold empty", cap_q, 300);
    temp_step = 4'd6;

    // R11 self-discharge limit
    soft_reset(1'b0);
    run(K_DSG, 1);
    run(K_SD, 4095);
    chk("R11 sd count", sd_cnt_q, 4095);
    chk("R5 vdq holds below limit", vdq_q, 1);
    chk("R2 sd counted only above zero", dcount_q, 300);
    run(K_SD, 1);
    chk("R11 sd count at limit", sd_cnt_q, 4096);
    chk("R5 vdq cleared at limit", vdq_q, 0);

    // R10 full events, self-discharge must not re-arm
    soft_reset(1'b1);
    run(K_CHG, 300);
    run(K_SD, 1);
    run(K_CHG, 1);
    for (int i = 0; i < 14; i++) begin run(K_DSG, 1); run(K_CHG, 1); end
    chk("R10 fifteen events", full_cnt_q, 0);
    run(K_DSG, 1); run(K_CHG, 1);
    chk("R10 sixteenth event", full_cnt_q, 1);

    // R12 discharge wins
    @(negedge clk); chg_stb = 1'b1; dsg_stb = 1'b1;
    @(negedge clk); chg_stb = 1'b0; dsg_stb = 1'b0;
    chk("R12 avail with both strobes", avail_q, 299);
    chk("R12 drawn with both strobes", dcount_q, 1);

    // R8 brp cleared by empty; R9 empty latch
    soft_reset(1'b1);
    run(K_DSG, 1);
    chk("R8 brp held while not full", brp_q, 1);
    pulse_empty();
    chk("R8 brp cleared by empty", brp_q, 0);
    run(K_CHG, 5);
    chk("R9 empty holds without valid charge", edv_q, 1);

    finish_run();
  end
endmodule